// File: doc/BRIEF.md
# Extended Page Addressing Override Sequencer

This block is the control side of a processor prefix instruction that overrides data paging for a short, counted run of following instructions. When the decoder issues the prefix, it hands over a 10-bit page operand and a 2-bit length code. The block latches both and opens an override window. While the window is open, the physical page number of every data access comes from the latched operand instead of the current data-page register. Register and bit-addressed special-function accesses are steered to the extended special-function space. Interrupts, peripheral event requests and low-class traps are held off.

Each instruction retired after the prefix shortens the window by one. When the count reaches zero, normal paging, the standard special-function space and interrupt delivery return. A high-class trap closes the window at once. A new prefix issued inside an open window restarts it with fresh operands.

The address path is combinational: the 14-bit page offset passes straight through, and only the 10-bit page number is selected. The window state is registered and changes only on clock edges.

Top module: `xpage_seq`

## Requirements
- R1: On a cycle with `pfx_issue` high and `trap_hi` low, the window counter loads the length `pfx_len_code + 1` (code 0 gives 1 instruction, code 3 gives 4), and the window is open from the next cycle.
- R2: While the window is open, `paddr[23:14]` equals the `pfx_page` value latched at the last issue, whatever `dpp_page` shows.
- R3: `paddr[13:0]` always equals `log_ofs` in the same cycle. While the window is closed, `paddr[23:14]` equals `dpp_page` in the same cycle.
- R4: `sfr_ext` (1 = extended space, 0 = standard space) and `irq_lock` are both high exactly while the window is open.
- R5: Each cycle with `retire` high and no issue or trap lowers a nonzero count by one. The window closes in the cycle after the retire that takes the count to zero. Without a retire, the count holds.
- R6: `trap_hi` high forces the count to zero at the next edge, so the window is closed in the following cycle. It takes priority over `pfx_issue` and `retire` in the same cycle.
- R7: A `retire` pulse in the same cycle as `pfx_issue` (the prefix's own retirement) does not decrement the new count.
- R8: While `rst_n` is low at a clock edge, the count is cleared, so `irq_lock` and `sfr_ext` are 0 and `paddr` uses `dpp_page`.
- R9: A prefix issued while the window is open reloads the count and replaces the latched page, with `irq_lock` staying high through the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_issue | input | 1 | Prefix instruction issued this cycle |
| pfx_page | input | 10 | Page operand carried by the prefix |
| pfx_len_code | input | 2 | Sequence length minus one |
| retire | input | 1 | One instruction retired this cycle |
| trap_hi | input | 1 | High-class trap condition |
| log_ofs | input | 14 | Page offset of the current data address request |
| dpp_page | input | 10 | Page number from the selected data-page register |
| paddr | output | 24 | Physical data address |
| sfr_ext | output | 1 | Special-function space select, 1 = extended |
| irq_lock | output | 1 | Interrupts and low-class traps blocked |

## Verification
Window state changes take one edge to show: after an issue, retire or trap sampled at edge k, `irq_lock`, `sfr_ext` and the page part of `paddr` reflect it in the cycle after edge k. The offset part of `paddr`, and the page part while the window is closed, follow their inputs in the same cycle with no register in between. The bench drives all inputs one time step after a rising edge and samples the outputs one more step later. Each output is therefore read in the cycle where it is due: one edge after a strobe, or immediately after a change on the address inputs. Boundary checks cover lengths 1 and 4, a retire in the issue cycle, a trap colliding with an issue, and a reissue inside an open window.

// File: rtl/xps_pkg.sv
// Package: shared widths and encodings for the extended page sequencer.
// Assumes a 24-bit physical data address split into page and offset.
package xps_pkg;

    // Page number width (upper address bits)
    localparam int unsigned PAGE_W = 10;
    // Page offset width (lower address bits)
    localparam int unsigned OFS_W  = 14;
    // Length code width; length = code + 1
    localparam int unsigned LEN_W  = 2;
    // Physical address width
    localparam int unsigned ADDR_W = PAGE_W + OFS_W;

    // Special-function space select encoding
    typedef enum logic {
        SFR_STD = 1'b0,
        SFR_EXT = 1'b1
    } sfr_space_e;

endpackage

// File: rtl/xps_seq_ctr.sv
// Module: xps_seq_ctr
// Holds the override window counter and the latched page operand.
// Priority at each edge: reset, then high-class trap, then prefix issue,
// then retire. A retire in the issue cycle belongs to the prefix itself
// and is therefore not counted. Assumes at most one retire per cycle.
module xps_seq_ctr #(
    parameter int unsigned LEN_W  = 2,
    parameter int unsigned PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [LEN_W-1:0]  len_code,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              retire,
    input  logic              trap_hi,
    output logic              active,
    output logic [PAGE_W-1:0] page_q
);

    // Counter must hold 2**LEN_W, one bit wider than the code
    localparam int unsigned CNT_W   = LEN_W + 1;
    localparam int unsigned MAX_LEN = 1 << LEN_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Length decode: code + 1 in counter width
    always_comb begin
        load_val = {1'b0, len_code} + CNT_W'(1);
    end

    // Window counter with trap > issue > retire priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trap_hi) begin
            cnt_q <= '0;
        end else if (issue) begin
            cnt_q <= load_val;
        end else if (retire && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Page operand latch, replaced on every accepted issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (issue && !trap_hi) begin
            page_q <= page_in;
        end
    end

    // Window open while the counter is nonzero
    always_comb begin
        active = (cnt_q != '0);
    end

    AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !trap_hi) |=> (cnt_q == {1'b0, $past(len_code)} + CNT_W'(1))); // R1
    AST_RETIRE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !issue && !trap_hi && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !issue && !trap_hi) |=> $stable(cnt_q)); // R5
    AST_TRAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        trap_hi |=> (cnt_q == '0)); // R6
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_LEN)); // R1
    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && !trap_hi) |=> $stable(page_q)); // R2

endmodule

// File: rtl/xps_addr_mux.sv
// Module: xps_addr_mux
// Forms the physical data address. The offset passes through untouched;
// the page number comes from the latched operand while the window is
// open and from the data-page register otherwise. Purely combinational.
module xps_addr_mux #(
    parameter int unsigned PAGE_W = 10,
    parameter int unsigned OFS_W  = 14
) (
    input  logic                     ovr_en,
    input  logic [PAGE_W-1:0]        ovr_page,
    input  logic [PAGE_W-1:0]        dpp_page,
    input  logic [OFS_W-1:0]         log_ofs,
    output logic [PAGE_W+OFS_W-1:0]  paddr
);

    logic [PAGE_W-1:0] page_sel;

    // Page source select
    always_comb begin
        page_sel = ovr_en ? ovr_page : dpp_page;
    end

    // Address assembly: page above offset
    always_comb begin
        paddr = {page_sel, log_ofs};
    end

endmodule

// File: rtl/xps_space_ctl.sv
// Module: xps_space_ctl
// Derives the special-function space select and the interrupt lock
// from the window state. Assumes both follow the window exactly.
module xps_space_ctl
    import xps_pkg::*;
(
    input  logic       active,
    output sfr_space_e space,
    output logic       irq_lock
);

    // Space steering: extended while the window is open
    always_comb begin
        space = active ? SFR_EXT : SFR_STD;
    end

    // Interrupt and low-class trap lock
    always_comb begin
        irq_lock = active;
    end

endmodule

// File: rtl/xpage_seq.sv
// Module: xpage_seq (top)
// Extended page addressing override sequencer. Connects the window
// counter, the address mux and the space/lock control. Assumes the
// decoder supplies the prefix operands already extracted and the
// address generator supplies the page offset of each data request.
module xpage_seq
    import xps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfx_issue,
    input  logic [PAGE_W-1:0] pfx_page,
    input  logic [LEN_W-1:0]  pfx_len_code,
    input  logic              retire,
    input  logic              trap_hi,
    input  logic [OFS_W-1:0]  log_ofs,
    input  logic [PAGE_W-1:0] dpp_page,
    output logic [ADDR_W-1:0] paddr,
    output logic              sfr_ext,
    output logic              irq_lock
);

    logic              win_active;
    logic [PAGE_W-1:0] win_page;
    sfr_space_e        space_sel;

    xps_seq_ctr #(
        .LEN_W  (LEN_W),
        .PAGE_W (PAGE_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (pfx_issue),
        .len_code (pfx_len_code),
        .page_in  (pfx_page),
        .retire   (retire),
        .trap_hi  (trap_hi),
        .active   (win_active),
        .page_q   (win_page)
    );

    xps_addr_mux #(
        .PAGE_W (PAGE_W),
        .OFS_W  (OFS_W)
    ) u_mux (
        .ovr_en   (win_active),
        .ovr_page (win_page),
        .dpp_page (dpp_page),
        .log_ofs  (log_ofs),
        .paddr    (paddr)
    );

    xps_space_ctl u_space (
        .active   (win_active),
        .space    (space_sel),
        .irq_lock (irq_lock)
    );

    // Export the space select as a plain bit
    always_comb begin
        sfr_ext = (space_sel == SFR_EXT);
    end

    AST_OFS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        paddr[OFS_W-1:0] == log_ofs); // R3
    AST_LOCK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lock == sfr_ext); // R4
    AST_IDLE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_lock |-> (paddr[ADDR_W-1:OFS_W] == dpp_page)); // R3
    AST_REISSUE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lock && pfx_issue && !trap_hi) |=> irq_lock); // R9

endmodule

// File: tb/xpage_seq_test.sv
// Directed bench for xpage_seq: one task per scenario.
// Inputs change 1 ns after a rising edge; outputs are sampled 1 ns later.
module xpage_seq_test;
    import xps_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pfx_issue = 1'b0;
    logic [PAGE_W-1:0] pfx_page = '0;
    logic [LEN_W-1:0]  pfx_len_code = '0;
    logic              retire = 1'b0;
    logic              trap_hi = 1'b0;
    logic [OFS_W-1:0]  log_ofs = '0;
    logic [PAGE_W-1:0] dpp_page = '0;
    logic [ADDR_W-1:0] paddr;
    logic              sfr_ext;
    logic              irq_lock;

    int ntest = 0;
    int nfail = 0;
    bit done  = 1'b0;

    xpage_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pfx_issue    (pfx_issue),
        .pfx_page     (pfx_page),
        .pfx_len_code (pfx_len_code),
        .retire       (retire),
        .trap_hi      (trap_hi),
        .log_ofs      (log_ofs),
        .dpp_page     (dpp_page),
        .paddr        (paddr),
        .sfr_ext      (sfr_ext),
        .irq_lock     (irq_lock)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        ntest++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Advance one edge, then settle inputs 1 ns after it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Check lock, space and full address against an expected window state
    task automatic check_state(input string req, input bit open,
                               input logic [PAGE_W-1:0] ovr);
        #1;
        check(req, "irq_lock", 32'(irq_lock), 32'(open));
        check(req, "sfr_ext", 32'(sfr_ext), 32'(open));
        check(req, "paddr", 32'(paddr),
              32'({(open ? ovr : dpp_page), log_ofs}));
    endtask

    task automatic issue(input logic [PAGE_W-1:0] pg, input logic [LEN_W-1:0] code,
                         input bit with_retire);
        pfx_issue = 1'b1; pfx_page = pg; pfx_len_code = code; retire = with_retire;
        tick();
        pfx_issue = 1'b0; retire = 1'b0; pfx_page = '0;
    endtask

    task automatic retire_one();
        retire = 1'b1;
        tick();
        retire = 1'b0;
    endtask

    task automatic t_reset();
        dpp_page = 10'h155; log_ofs = 14'h1234;
        pfx_issue = 1'b1; pfx_page = 10'h3FF; pfx_len_code = 2'd3;
        tick(); tick();
        pfx_issue = 1'b0;
        check_state("R8", 1'b0, '0);
        rst_n = 1'b1;
        tick();
        check_state("R8", 1'b0, '0);
    endtask

    task automatic t_basic();
        // length code 2 -> three instructions; prefix retire ignored (R7)
        dpp_page = 10'h0A0; log_ofs = 14'h0ABC;
        issue(10'h2A5, 2'd2, 1'b1);
        check_state("R1", 1'b1, 10'h2A5);
        dpp_page = 10'h011; log_ofs = 14'h3FFF;
        check_state("R2", 1'b1, 10'h2A5);
        retire_one();
        check_state("R7", 1'b1, 10'h2A5);
        tick(); tick();
        check_state("R5", 1'b1, 10'h2A5);
        retire_one();
        check_state("R5", 1'b1, 10'h2A5);
        retire_one();
        check_state("R5", 1'b0, '0);
        dpp_page = 10'h2C3; log_ofs = 14'h0001;
        check_state("R3", 1'b0, '0);
        check("R4", "sfr_ext idle", 32'(sfr_ext), 32'(0));
    endtask

    task automatic t_bounds();
        issue(10'h001, 2'd0, 1'b0);
        check_state("R1", 1'b1, 10'h001);
        retire_one();
        check_state("R1", 1'b0, '0);
        issue(10'h3C0, 2'd3, 1'b0);
        for (int i = 0; i < 3; i++) begin
            retire_one();
            check_state("R1", 1'b1, 10'h3C0);
        end
        retire_one();
        check_state("R1", 1'b0, '0);
    endtask

    task automatic t_trap();
        issue(10'h0F0, 2'd3, 1'b0);
        retire_one();
        check_state("R6", 1'b1, 10'h0F0);
        trap_hi = 1'b1; retire = 1'b1;
        tick();
        trap_hi = 1'b0; retire = 1'b0;
        check_state("R6", 1'b0, '0);
        trap_hi = 1'b1; pfx_issue = 1'b1; pfx_page = 10'h111; pfx_len_code = 2'd1;
        tick();
        trap_hi = 1'b0; pfx_issue = 1'b0;
        check_state("R6", 1'b0, '0);
    endtask

    task automatic t_reissue();
        issue(10'h0AA, 2'd1, 1'b0);
        retire_one();
        check_state("R9", 1'b1, 10'h0AA);
        issue(10'h355, 2'd1, 1'b1);
        check_state("R9", 1'b1, 10'h355);
        retire_one();
        check_state("R9", 1'b1, 10'h355);
        retire_one();
        check_state("R9", 1'b0, '0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_bounds();
        t_trap();
        t_reissue();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

endmodule